// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block sequences the self- and system-calibration routines of a sigma-delta converter. Writing a mode code with its top bit set starts one of four routines on the currently selected input channel: internal zero-scale, internal full-scale, system zero-scale or system full-scale. While the routine runs, the ready flag reads busy. The speed-up filter options are suppressed so that the full filter settles. The routine then counts output-rate strobes until its length is reached.

The length depends on the routine and on whether chopping is enabled. When the count expires, the block does three things in the same clock edge:
- it captures the measured result;
- it raises a one-cycle write enable for that channel's offset register (zero-scale routines) or gain register (full-scale routines);
- it returns the mode field to idle and clears the busy flag.

Internal routines always run with dc excitation. System routines pass the ac-excitation request through unchanged.

Top module: `cal_seq_ctrl`

## Requirements
- R1: After reset the busy flag is 0, the mode field is 000 and no write enable is asserted.
- R2: A mode write with code 100 (internal zero), 101 (internal full), 110 (system zero) or 111 (system full) makes busy 1 and stores the code in the mode field at the next clock edge.
- R3: With chopping enabled at the start, a routine lasts 22 rate strobes, or 44 for code 101. Busy stays 1 after one strobe fewer than that.
- R4: With chopping disabled at the start, the lengths are 24 strobes, and 48 for code 101.
- R5: On the edge that samples the final strobe, busy returns to 0 and the mode field returns to 000.
- R6: The effective fast and skip filter controls are 0 while busy is 1, and they follow their request inputs while busy is 0.
- R7: On completion exactly one write enable pulses for one cycle: `off_we[ch]` for codes 100 and 110, `gain_we[ch]` for codes 101 and 111. At the same time `cal_data` holds `result_in` as sampled with the final strobe.
- R8: The ac-excitation output is 0 during codes 100 and 101, and it follows `ac_en` during codes 110 and 111 and when idle.
- R9: A mode write while busy aborts the routine without any register write, even in the cycle of the final strobe. If the new code starts a routine, that routine counts from zero.
- R10: The channel is latched when the routine starts, and later changes of `chan_sel` do not alter which register is written.
- R11: A mode write with a code below 100 stores the code and leaves busy at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Mode field write strobe |
| mode_wdata | input | 3 | Mode code being written |
| chop_en | input | 1 | Chopping enabled |
| ac_en | input | 1 | ac excitation requested |
| chan_sel | input | 1 | Selected input channel |
| fast_req | input | 1 | Fast filter option request |
| skip_req | input | 1 | Skip filter option request |
| rate_tick | input | 1 | One-cycle strobe per filter output period |
| result_in | input | DW | Measured calibration result |
| busy | output | 1 | Ready flag, 1 while a routine runs |
| mode_q | output | 3 | Current mode field |
| fast_eff | output | 1 | Effective fast filter control |
| skip_eff | output | 1 | Effective skip filter control |
| excit_ac | output | 1 | ac excitation active |
| off_we | output | 2 | Offset register write enable per channel |
| gain_we | output | 2 | Gain register write enable per channel |
| cal_data | output | DW | Value to commit |

## Verification
Two functions can fall in the same cycle: expiry of the period count and a new mode write that aborts the routine. The bench provokes this by asserting the final rate strobe together with a fresh start code. It then requires that no write enable appears, that busy stays 1, and that the new routine needs its full strobe count before its single commit. The scoreboard flags any write enable for which no commit was queued.

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl #(
  parameter int DW          = 24,
  parameter int LEN_CHOP    = 22,
  parameter int LEN_NOCHOP  = 24,
  parameter int LONG_CHOP   = 44,
  parameter int LONG_NOCHOP = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic [2:0]    mode_wdata,
  input  logic          chop_en,
  input  logic          ac_en,
  input  logic          chan_sel,
  input  logic          fast_req,
  input  logic          skip_req,
  input  logic          rate_tick,
  input  logic [DW-1:0] result_in,
  output logic          busy,
  output logic [2:0]    mode_q,
  output logic          fast_eff,
  output logic          skip_eff,
  output logic          excit_ac,
  output logic [1:0]    off_we,
  output logic [1:0]    gain_we,
  output logic [DW-1:0] cal_data
);
  localparam int MAXLEN = (LONG_NOCHOP > LONG_CHOP) ? LONG_NOCHOP : LONG_CHOP;
  localparam int CW     = $clog2(MAXLEN + 1);

  logic [CW-1:0] cnt, lim, start_lim;
  logic          ch_q;
  logic          last;

  always_comb begin
    if (mode_wdata == 3'b101) start_lim = chop_en ? CW'(LONG_CHOP) : CW'(LONG_NOCHOP);
    else                      start_lim = chop_en ? CW'(LEN_CHOP)  : CW'(LEN_NOCHOP);
  end

  assign last     = busy && rate_tick && (cnt == lim - CW'(1));
  assign fast_eff = fast_req && !busy;
  assign skip_eff = skip_req && !busy;
  assign excit_ac = ac_en && !(busy && !mode_q[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      mode_q   <= 3'b000;
      cnt      <= '0;
      lim      <= '0;
      ch_q     <= 1'b0;
      off_we   <= 2'b00;
      gain_we  <= 2'b00;
      cal_data <= '0;
    end else begin
      off_we  <= 2'b00;
      gain_we <= 2'b00;
      if (mode_wr) begin
        mode_q <= mode_wdata;
        busy   <= mode_wdata[2];
        cnt    <= '0;
        lim    <= start_lim;
        ch_q   <= chan_sel;
      end else if (last) begin
        busy     <= 1'b0;
        mode_q   <= 3'b000;
        cnt      <= '0;
        cal_data <= result_in;
        if (mode_q[0]) gain_we[ch_q] <= 1'b1;
        else           off_we[ch_q]  <= 1'b1;
      end else if (busy && rate_tick) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy && mode_q == 3'b000 && off_we == 2'b00 && gain_we == 2'b00);

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && mode_wdata[2] |=> busy && mode_q == $past(mode_wdata));

  a_r5_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(mode_wr) |-> mode_q == 3'b000);

  a_r7_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({off_we, gain_we}));

  a_r7_write_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (|{off_we, gain_we}) |-> $fell(busy));

  a_r9_no_write_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> !(|{off_we, gain_we}));

  a_r11_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && !mode_wdata[2] |=> !busy);
endmodule

// File: tb/test_cal_seq_ctrl.sv
module test_cal_seq_ctrl;
  localparam int DW = 24;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_wr = 0, chop_en = 1, ac_en = 0, chan_sel = 0, fast_req = 1, skip_req = 1, rate_tick = 0;
  logic [2:0] mode_wdata = 3'b000;
  logic [DW-1:0] result_in = '0;
  logic busy, fast_eff, skip_eff, excit_ac;
  logic [2:0] mode_q;
  logic [1:0] off_we, gain_we;
  logic [DW-1:0] cal_data;
  int checks = 0, fails = 0;
  logic [DW+1:0] expq[$];

  always #5 clk = ~clk;

  cal_seq_ctrl #(.DW(DW)) i_cal_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .chop_en(chop_en), .ac_en(ac_en), .chan_sel(chan_sel), .fast_req(fast_req),
    .skip_req(skip_req), .rate_tick(rate_tick), .result_in(result_in),
    .busy(busy), .mode_q(mode_q), .fast_eff(fast_eff), .skip_eff(skip_eff),
    .excit_ac(excit_ac), .off_we(off_we), .gain_we(gain_we), .cal_data(cal_data));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // monitor: every write enable must match the oldest queued commit (R7, R10)
  always @(negedge clk) begin
    if (rst_n && (|{off_we, gain_we})) begin
      logic [DW+1:0] e, a;
      a = {|gain_we, gain_we[1] | off_we[1], cal_data};
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R7/R9 actual=%0h expected=no write", a);
      end else begin
        e = expq.pop_front();
        if (a !== e || $countones({off_we, gain_we}) != 1) begin
          fails++;
          $display("FAIL R7/R10 actual=%0h expected=%0h", a, e);
        end
      end
    end
  end

  task automatic write_mode(input logic [2:0] code);
    @(negedge clk); mode_wr = 1; mode_wdata = code;
    @(negedge clk); mode_wr = 0;
  endtask

  task automatic tick(input logic [DW-1:0] v);
    @(negedge clk); rate_tick = 1; result_in = v;
    @(negedge clk); rate_tick = 0;
  endtask

  task automatic run_cal(input logic [2:0] code, input logic chop, input logic ac,
                         input logic ch, input logic [DW-1:0] v, input int n);
    chop_en = chop; ac_en = ac; chan_sel = ch;
    write_mode(code);
    chk("R2 busy", busy, 1); chk("R2 mode", mode_q, code);
    chk("R6 fast", fast_eff, 0); chk("R6 skip", skip_eff, 0);
    chk("R8 excit", excit_ac, ac & code[1]);
    chan_sel = ~ch;
    chop_en = ~chop;
    for (int i = 0; i < n - 1; i++) tick(DW'(i));
    chk(chop ? "R3 busy before end" : "R4 busy before end", busy, 1);
    expq.push_back({code[0], ch, v});
    tick(v);
    chk(chop ? "R3 done" : "R4 done", busy, 0);
    chk("R5 mode idle", mode_q, 0);
    chk("R6 fast idle", fast_eff, fast_req);
    @(negedge clk);
    chk("R7 pulse one cycle", {off_we, gain_we}, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 busy", busy, 0); chk("R1 mode", mode_q, 0);
        chk("R1 we", {off_we, gain_we}, 0);
        chk("R6 idle pass", {fast_eff, skip_eff}, 2'b11);
        ac_en = 1; #1 chk("R8 idle ac", excit_ac, 1);

        run_cal(3'b100, 1, 1, 0, 24'h00A5A5, 22);
        run_cal(3'b101, 1, 1, 1, 24'h123456, 44);
        run_cal(3'b110, 1, 1, 1, 24'hABCDEF, 22);
        run_cal(3'b111, 1, 1, 0, 24'h0F0F0F, 22);
        run_cal(3'b100, 0, 0, 1, 24'h111111, 24);
        run_cal(3'b101, 0, 1, 0, 24'h222222, 48);
        run_cal(3'b111, 0, 1, 1, 24'h333333, 24);

        // R11 non-calibration code
        write_mode(3'b011);
        chk("R11 busy", busy, 0); chk("R11 mode", mode_q, 3'b011);

        // R9 abort mid-run, then abort on the final strobe cycle
        chop_en = 1; chan_sel = 0;
        write_mode(3'b110);
        for (int i = 0; i < 10; i++) tick(24'h5);
        write_mode(3'b100);
        chk("R9 restarted busy", busy, 1);
        for (int i = 0; i < 21; i++) tick(24'h6);
        @(negedge clk); rate_tick = 1; mode_wr = 1; mode_wdata = 3'b100; chan_sel = 1;
        @(negedge clk); rate_tick = 0; mode_wr = 0;
        chk("R9 coincident no end", busy, 1);
        chk("R9 coincident no write", {off_we, gain_we}, 0);
        for (int i = 0; i < 21; i++) tick(24'h7);
        chk("R9 count from zero", busy, 1);
        expq.push_back({1'b0, 1'b1, 24'h777777});
        tick(24'h777777);
        chk("R9 final", busy, 0);
        write_mode(3'b000);
        chk("R11 idle write", busy, 0);
        repeat (3) @(negedge clk);
        chk("R7 all commits seen", expq.size(), 0);
      end
      begin
        repeat (20000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule